// File: doc/BRIEF.md
# Four-Phase Instruction Cycle Sequencer

This block sets the instruction-cycle timing of a small microcontroller core. It divides the system clock into four phase strobes, T1 to T4. Exactly one strobe is high in each clock, and together the four form one instruction cycle. The block owns the program counter and drives a program memory read port. While the execute side works on the current instruction during T2 to T4, the next word is already being fetched. Without branches the core therefore completes one instruction per instruction cycle.

The execute unit sits outside this block. It sees the instruction register, its valid flag and the phase vector. To take a branch, it raises a request with a target address. The request is sampled at the end of T4. The prefetched word is then dropped, so the next cycle executes a bubble, and the target is fetched in that same cycle. A T1 sync output, high for one clock in every four, lets external logic follow the instruction cycle.

Program memory is a synchronous read port with one clock of latency. The address and read strobe are presented during T1, and the word must be on `imem_rdata` throughout T2. The word is not needed outside T2. The port has no back-pressure, because a fetch is issued in every instruction cycle and is never retried.

Top module: `icycle_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block sets `phase` to 4'b0001 (T1), `imem_addr` to 0, `ir_valid` to 0 and `t1_sync` to 1. The first clock after release is a T1 that fetches address 0.
- R2: `phase` is one-hot, with bit 0 = T1, bit 1 = T2, bit 2 = T3 and bit 3 = T4. It advances one position per clock, from T1 to T2 to T3 to T4 and back to T1.
- R3: `t1_sync` is high in exactly the T1 clock of each instruction cycle and low in the other three (1:3 duty, a quarter of the clock rate).
- R4: `imem_rd` is high only during T1. `imem_addr` holds the program counter and does not change during T2, T3 or T4.
- R5: On each entry to T1 other than the first after reset, the program counter advances by one when no branch is taken. It wraps modulo 2^12, so 12'hFFF is followed by 12'h000.
- R6: The word on `imem_rdata` at the end of T2 appears on `ir_q` from the next T1, with `ir_valid` = 1. A run without branches issues one valid instruction per instruction cycle, in address order.
- R7: If `br_req` is high at the end of T4 while `ir_valid` = 1, the next T1 fetches `br_target` and shows `ir_valid` = 0. The cycle after that executes the target word with `ir_valid` = 1.
- R8: `br_req` has no effect when it is high outside the last clock of T4, or when `ir_valid` = 0.
- R9: `ir_q` and `ir_valid` change only on entry to T1 and stay stable through T2 to T4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 12 | Program memory read address (program counter) |
| imem_rd | output | 1 | Fetch strobe, high during T1 |
| imem_rdata | input | 16 | Program memory word, valid throughout T2 |
| br_req | input | 1 | Branch taken by the executing instruction, sampled at end of T4 |
| br_target | input | 12 | Branch target address, sampled with `br_req` |
| ir_q | output | 16 | Instruction being executed |
| ir_valid | output | 1 | `ir_q` holds a real instruction (0 = bubble) |
| phase | output | 4 | One-hot phase vector, bit 0 = T1 to bit 3 = T4 |
| t1_sync | output | 1 | T1 sync strobe, 1:3 duty |

## Verification
The hardest cases to reach are branch requests that must be ignored. These include a request during the bubble right after a taken branch, a request in the first cycle after reset, and a request held high in T1 to T3 but dropped before T4 ends. The directed part builds each of these on purpose, including two branches back to back and a branch to 12'hFFF that forces the wrap. The random part toggles the request in the non-sampling phases on about half of the cycles and takes real branches on about a quarter. The bench memory holds each word on its read data only during T2 and shows unrelated data elsewhere, so sampling in the wrong phase shows up as a wrong instruction.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int NUM_PHASES = 4;
  typedef logic [NUM_PHASES-1:0] phase_vec_t;
  localparam phase_vec_t PHASE_T1 = phase_vec_t'(1);
endpackage

// File: rtl/seq_phase_gen.sv
module seq_phase_gen
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  output phase_vec_t ring_o,
  output logic       sync_o
);
  phase_vec_t ring_q;
  logic       sync_q;

  // rotating one-hot ring, one stage per phase
  for (genvar i = 0; i < NUM_PHASES; i++) begin : g_ring
    localparam int PREV = (i == 0) ? NUM_PHASES - 1 : i - 1;
    always_ff @(posedge clk) begin
      if (!rst_n) ring_q[i] <= PHASE_T1[i];
      else        ring_q[i] <= ring_q[PREV];
    end
  end

  // separate sync flop: high in the clock that follows the last phase
  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= 1'b1;
    else        sync_q <= ring_q[NUM_PHASES-1];
  end

  assign ring_o = ring_q;
  assign sync_o = sync_q;
endmodule

// File: rtl/seq_pc_unit.sv
module seq_pc_unit #(
  parameter int PC_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cycle_end,
  input  logic            redirect,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc_o
);
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_next;

  always_comb begin
    pc_next = pc_q;
    if (cycle_end) pc_next = redirect ? target : pc_q + PC_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_next;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/seq_fetch_stage.sv
module seq_fetch_stage #(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          cycle_end,
  input  logic          br_req,
  input  logic [IW-1:0] rdata,
  output logic          redirect_o,
  output logic [IW-1:0] ir_o,
  output logic          valid_o
);
  logic [IW-1:0] pref_q;
  logic [IW-1:0] ir_q;
  logic          valid_q;
  logic          redirect;

  // a branch counts only from a real instruction at the last phase
  assign redirect = cycle_end & br_req & valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       pref_q <= '0;
    else if (capture) pref_q <= rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ir_q    <= '0;
      valid_q <= 1'b0;
    end else if (cycle_end) begin
      ir_q    <= pref_q;
      valid_q <= ~redirect;
    end
  end

  assign redirect_o = redirect;
  assign ir_o       = ir_q;
  assign valid_o    = valid_q;
endmodule

// File: rtl/icycle_seq.sv
module icycle_seq
  import seq_pkg::*;
#(
  parameter int PC_W = 12,
  parameter int IW   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic [PC_W-1:0]       imem_addr,
  output logic                  imem_rd,
  input  logic [IW-1:0]         imem_rdata,
  input  logic                  br_req,
  input  logic [PC_W-1:0]       br_target,
  output logic [IW-1:0]         ir_q,
  output logic                  ir_valid,
  output logic [NUM_PHASES-1:0] phase,
  output logic                  t1_sync
);
  localparam int CAP_PH = 1;
  localparam int END_PH = NUM_PHASES - 1;

  phase_vec_t ring;
  logic       redirect;

  seq_phase_gen u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .ring_o (ring),
    .sync_o (t1_sync)
  );

  seq_fetch_stage #(.IW(IW)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (ring[CAP_PH]),
    .cycle_end  (ring[END_PH]),
    .br_req     (br_req),
    .rdata      (imem_rdata),
    .redirect_o (redirect),
    .ir_o       (ir_q),
    .valid_o    (ir_valid)
  );

  seq_pc_unit #(.PC_W(PC_W)) u_pc (
    .clk       (clk),
    .rst_n     (rst_n),
    .cycle_end (ring[END_PH]),
    .redirect  (redirect),
    .target    (br_target),
    .pc_o      (imem_addr)
  );

  assign imem_rd = ring[0];
  assign phase   = ring;
endmodule

// File: rtl/icycle_seq_chk.sv
module icycle_seq_chk #(
  parameter int PC_W = 12,
  parameter int IW   = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] imem_addr,
  input logic            imem_rd,
  input logic            br_req,
  input logic [PC_W-1:0] br_target,
  input logic [IW-1:0]   ir_q,
  input logic            ir_valid,
  input logic [3:0]      phase,
  input logic            t1_sync
);
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase) == 1);

  p_wrap_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase[3] |=> phase[0]);

  p_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    t1_sync == phase[0]);

  p_rd_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    imem_rd |-> (t1_sync && !phase[3]));

  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !phase[0] |-> $stable(imem_addr));

  p_pc_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[0] && $past(phase[3]) && !$past(br_req && ir_valid))
      |-> imem_addr == PC_W'($past(imem_addr) + 1));

  p_branch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[0] && $past(phase[3]) && $past(br_req && ir_valid))
      |-> (imem_addr == $past(br_target) && !ir_valid));

  p_ir_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !phase[0] |-> ($stable(ir_q) && $stable(ir_valid)));
endmodule

bind icycle_seq icycle_seq_chk #(.PC_W(PC_W), .IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .imem_addr (imem_addr),
  .imem_rd   (imem_rd),
  .br_req    (br_req),
  .br_target (br_target),
  .ir_q      (ir_q),
  .ir_valid  (ir_valid),
  .phase     (phase),
  .t1_sync   (t1_sync)
);

// File: tb/icycle_seq_bench.sv
`timescale 1ns/1ps
module icycle_seq_bench;
  localparam int PC_W = 12;
  localparam int IW   = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PC_W-1:0] imem_addr;
  logic            imem_rd;
  logic [IW-1:0]   imem_rdata = '0;
  logic            br_req = 1'b0;
  logic [PC_W-1:0] br_target = '0;
  logic [IW-1:0]   ir_q;
  logic            ir_valid;
  logic [3:0]      phase;
  logic            t1_sync;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [PC_W-1:0] exp_pc;
  logic            exp_valid;
  logic [IW-1:0]   exp_ir;

  always #4 clk = ~clk;

  icycle_seq #(.PC_W(PC_W), .IW(IW)) u_icycle_seq (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rd(imem_rd),
    .imem_rdata(imem_rdata), .br_req(br_req), .br_target(br_target),
    .ir_q(ir_q), .ir_valid(ir_valid), .phase(phase), .t1_sync(t1_sync)
  );

  function automatic logic [IW-1:0] memf(input logic [PC_W-1:0] a);
    logic [31:0] t;
    t = {20'd0, a} * 32'd40503 ^ 32'h3C5A;
    return t[IW-1:0];
  endfunction

  // memory model: word valid only in the clock after a read strobe
  always_ff @(posedge clk) begin
    if (imem_rd) imem_rdata <= memf(imem_addr);
    else         imem_rdata <= IW'($urandom);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    exp_pc    = '0;
    exp_valid = 1'b0;
    exp_ir    = '0;
  endtask

  // called at the negedge inside T1; returns at the negedge of the next T1
  task automatic run_cycle(input bit br, input logic [PC_W-1:0] tgt, input bit noise);
    logic [PC_W-1:0] a0;
    logic [IW-1:0]   ir0;
    logic            v0;
    bit              take;
    check("R4 addr at T1", 32'(imem_addr), 32'(exp_pc));
    check("R6/R7 valid at T1", 32'(ir_valid), 32'(exp_valid));
    if (exp_valid) check("R6 ir at T1", 32'(ir_q), 32'(exp_ir));
    a0 = imem_addr; ir0 = ir_q; v0 = ir_valid;
    for (int p = 0; p < 4; p++) begin
      if (p > 0) begin
        check("R4 addr stable", 32'(imem_addr), 32'(a0));
        check("R9 ir stable", 32'({v0, ir0}), 32'({ir_valid, ir_q}));
      end
      check("R2 phase", 32'(phase), 32'(1 << p));
      check("R3 t1_sync", 32'(t1_sync), 32'(p == 0));
      check("R4 imem_rd", 32'(imem_rd), 32'(p == 0));
      br_req    = (p == 3) ? br : noise;
      br_target = (p == 3) ? tgt : PC_W'($urandom);
      @(negedge clk);
    end
    br_req = 1'b0;
    take = br && exp_valid;
    exp_ir    = memf(exp_pc);
    exp_valid = !take;
    exp_pc    = take ? tgt : exp_pc + PC_W'(1);
  endtask

  task automatic do_reset(input int n);
    @(negedge clk);
    rst_n = 1'b0;
    br_req = 1'b0;
    repeat (n) @(negedge clk);
    check("R1 phase in reset", 32'(phase), 32'h1);
    check("R1 addr in reset", 32'(imem_addr), 32'h0);
    check("R1 valid in reset", 32'(ir_valid), 32'h0);
    check("R1 sync in reset", 32'(t1_sync), 32'h1);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #1200000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset(3);
    // R8: request in the bubble right after reset is ignored
    run_cycle(1'b1, 12'h123, 1'b0);
    check("R8 ignored after reset", 32'(imem_addr), 32'h1);
    // R6: plain sequential run, with noise on br_req outside T4 (R8)
    for (int i = 0; i < 6; i++) run_cycle(1'b0, '0, i[0]);
    // R7: branch to end of space, R5 wrap afterwards
    run_cycle(1'b1, 12'hFFF, 1'b0);
    check("R7 redirect addr", 32'(imem_addr), 32'hFFF);
    check("R7 bubble", 32'(ir_valid), 32'h0);
    // R8: request during the bubble is ignored
    run_cycle(1'b1, 12'h055, 1'b1);
    check("R5 wrap to zero", 32'(imem_addr), 32'h000);
    run_cycle(1'b0, '0, 1'b0);
    // back-to-back branches
    run_cycle(1'b1, 12'h200, 1'b0);
    run_cycle(1'b1, 12'h300, 1'b0);
    run_cycle(1'b1, 12'h400, 1'b0);
    run_cycle(1'b0, '0, 1'b1);
    run_cycle(1'b0, '0, 1'b0);
    // mid-run reset, R1
    do_reset(5);
    run_cycle(1'b0, '0, 1'b1);
    check("R1 first fetch after reset", 32'(imem_addr), 32'h1);
    // random mix
    for (int i = 0; i < 400; i++) begin
      bit br;
      br = ($urandom % 4) == 0;
      run_cycle(br, PC_W'($urandom), ($urandom % 2) == 1);
    end
    finish_run();
  end
endmodule